// File: doc/BRIEF.md
# Decimal Arithmetic Adjust Unit

This unit applies decimal correction to an accumulator pair, a low byte and a high byte, after a binary add, subtract, multiply or before a divide. The incoming carry and auxiliary-carry flags steer the correction. Six operations are supported:

- unpacked (one digit per byte) add and subtract adjust;
- packed (two digits per byte) add and subtract adjust;
- a split of the low byte into quotient and remainder by a base;
- a fold of the high byte times a base into the low byte.

The result and all flags are registered, so they appear one cycle after the request. Opcode decoding and flag storage stay with the caller.

Top module: `dau_top`

## Requirements
- R1: Synchronous active-high reset clears every output to 0. A request on `req_valid` produces `rsp_valid` exactly one clock later. Without a request, all result outputs hold their previous values.
- R2: Operation code 0 (unpacked add) adjusts when AL[3:0] > 9 or AF_in = 1. On an adjust, AL becomes (AL+6) mod 16, AH becomes AH+1 (mod 256), and CF = AF = 1. Otherwise AL becomes AL mod 16, AH is kept, and CF = AF = 0.
- R3: In unpacked add, when an adjust happens and AL > 0xF9, AH is incremented by 2 instead of 1.
- R4: Operation code 1 (unpacked subtract) uses the same adjust condition and flags as R2. On an adjust, AL becomes (AL−6) mod 16 and AH becomes AH−1 (mod 256), or AH−2 when AL < 6.
- R5: Operation code 2 (packed add) works on a cleared flag set. It adds 6 and sets AF when AL[3:0] > 9 or AF_in = 1. It then adds 0x60 and sets CF when the original AL > 0x99 or CF_in = 1.
- R6: Operation code 3 (packed subtract) applies the low-digit step when AL[3:0] > 9 or AF_in = 1. That step sets AF, sets CF when AL < 6 or CF_in = 1, and subtracts 6. The high-digit step then subtracts 0x60 and sets CF when the original AL > 0x99 or CF_in = 1.
- R7: For every operation without error, ZF = (result AL == 0), SF = result AL bit 7, and PF = 1 when result AL has an even number of one bits. Operation codes 4 and 5 clear CF and AF.
- R8: Operation code 4 (multiply adjust) with a nonzero base sets AH = AL / base and AL = AL mod base.
- R9: Operation code 5 (divide prepare) sets AL = (AH·base + AL) mod 256 and AH = 0.
- R10: Operation code 4 with base 0, and the reserved codes 6 and 7, raise `rsp_err`. In that case AL and AH come out unchanged, CF and AF pass through, and ZF/SF/PF describe the unchanged AL.
- R11: Packed adjusts (codes 2 and 3) leave AH unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0..5, 6 and 7 reserved) |
| req_lo | input | 8 | Accumulator low byte (AL) |
| req_hi | input | 8 | Accumulator high byte (AH) |
| req_cf | input | 1 | Incoming carry flag |
| req_af | input | 1 | Incoming auxiliary-carry flag |
| req_base | input | 8 | Base for codes 4 and 5 |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_lo | output | 8 | New AL |
| rsp_hi | output | 8 | New AH |
| rsp_cf | output | 1 | Carry flag |
| rsp_af | output | 1 | Auxiliary-carry flag |
| rsp_zf | output | 1 | Zero flag |
| rsp_sf | output | 1 | Sign flag |
| rsp_pf | output | 1 | Parity flag (1 = even count of ones) |
| rsp_err | output | 1 | Divide-by-zero base or reserved code |

## Verification
In packed subtract, the low-digit correction and the high-digit correction can both fire in the same operation. Each of them can set CF.

The bench provokes this with AL = 0x03 and AF set:

- with CF_in clear, only the low-digit step applies and must give 0xFD with CF set;
- with CF_in set, both steps apply and must give 0x9D.

The same collision is swept across every AL value with all four flag combinations. Each result is judged against an expectation computed from the stated rules.

// File: rtl/dau_pkg.sv
package dau_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int PROD_W = 2 * BYTE_W;

    localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] LO_FIX    = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HI_FIX    = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] PACK_MAX  = BYTE_W'(8'h99);
    localparam logic [BYTE_W-1:0] WRAP_LIM  = BYTE_W'(8'hF9);

    typedef enum logic [2:0] {
        OP_UADD  = 3'd0,
        OP_USUB  = 3'd1,
        OP_PADD  = 3'd2,
        OP_PSUB  = 3'd3,
        OP_MADJ  = 3'd4,
        OP_DPREP = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } dau_op_e;

    // Result of one adjust path before the common flags are added
    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              cf;
        logic              af;
    } adj_res_t;

    // Registered response
    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              cf;
        logic              af;
        logic              zf;
        logic              sf;
        logic              pf;
        logic              err;
    } dau_rsp_t;

    function automatic logic digit_over(input logic [BYTE_W-1:0] b);
        return b[NIB_W-1:0] > DIGIT_MAX;
    endfunction

    function automatic logic even_ones(input logic [BYTE_W-1:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/dau_unpacked.sv
module dau_unpacked
    import dau_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              af,
    output adj_res_t          res
);
    logic              fix;
    logic              extra;
    logic [BYTE_W-1:0] moved;
    logic [BYTE_W-1:0] hi_step;

    assign fix = digit_over(lo) || af;

    generate
        if (SUBTRACT) begin : g_sub
            assign extra   = lo < LO_FIX;
            assign moved   = lo - LO_FIX;
            assign hi_step = hi - BYTE_W'(1) - BYTE_W'(extra);
        end else begin : g_add
            assign extra   = lo > WRAP_LIM;
            assign moved   = lo + LO_FIX;
            assign hi_step = hi + BYTE_W'(1) + BYTE_W'(extra);
        end
    endgenerate

    always_comb begin
        res = '0;
        if (fix) begin
            res.lo = {{NIB_W{1'b0}}, moved[NIB_W-1:0]};
            res.hi = hi_step;
            res.cf = 1'b1;
            res.af = 1'b1;
        end else begin
            res.lo = {{NIB_W{1'b0}}, lo[NIB_W-1:0]};
            res.hi = hi;
        end
    end
endmodule

// File: rtl/dau_packed.sv
module dau_packed
    import dau_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              cf,
    input  logic              af,
    output adj_res_t          res
);
    logic              fix_lo;
    logic              fix_hi;
    logic              lo_borrow;
    logic [BYTE_W-1:0] stage1;
    logic [BYTE_W-1:0] stage2;

    assign fix_lo = digit_over(lo) || af;
    assign fix_hi = (lo > PACK_MAX) || cf;

    generate
        if (SUBTRACT) begin : g_sub
            assign lo_borrow = fix_lo && ((lo < LO_FIX) || cf);
            assign stage1    = fix_lo ? (lo - LO_FIX) : lo;
            assign stage2    = fix_hi ? (stage1 - HI_FIX) : stage1;
        end else begin : g_add
            assign lo_borrow = 1'b0;
            assign stage1    = fix_lo ? (lo + LO_FIX) : lo;
            assign stage2    = fix_hi ? (stage1 + HI_FIX) : stage1;
        end
    endgenerate

    always_comb begin
        res.lo = stage2;
        res.hi = hi;
        res.af = fix_lo;
        res.cf = fix_hi || lo_borrow;
    end
endmodule

// File: rtl/dau_base.sv
module dau_base
    import dau_pkg::*;
(
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] base,
    output adj_res_t          split_res,
    output adj_res_t          fold_res
);
    logic [BYTE_W-1:0] quo;
    logic [BYTE_W:0]   rem;
    logic [PROD_W-1:0] prod;

    // Restoring division, one quotient bit per step
    always_comb begin
        quo = '0;
        rem = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            rem = {rem[BYTE_W-1:0], lo[i]};
            if (rem >= {1'b0, base}) begin
                rem    = rem - {1'b0, base};
                quo[i] = 1'b1;
            end
        end
    end

    assign prod = ({{BYTE_W{1'b0}}, hi} * {{BYTE_W{1'b0}}, base})
                + {{BYTE_W{1'b0}}, lo};

    always_comb begin
        split_res    = '0;
        split_res.lo = rem[BYTE_W-1:0];
        split_res.hi = quo;
        fold_res     = '0;
        fold_res.lo  = prod[BYTE_W-1:0];
    end
endmodule

// File: rtl/dau_top.sv
module dau_top
    import dau_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [7:0] req_lo,
    input  logic [7:0] req_hi,
    input  logic       req_cf,
    input  logic       req_af,
    input  logic [7:0] req_base,
    output logic       rsp_valid,
    output logic [7:0] rsp_lo,
    output logic [7:0] rsp_hi,
    output logic       rsp_cf,
    output logic       rsp_af,
    output logic       rsp_zf,
    output logic       rsp_sf,
    output logic       rsp_pf,
    output logic       rsp_err
);
    dau_op_e  op;
    adj_res_t r_uadd, r_usub, r_padd, r_psub, r_split, r_fold, pick;
    logic     fault;
    dau_rsp_t nxt, cur;
    logic     vld_q;

    assign op = dau_op_e'(req_op);

    dau_unpacked #(.SUBTRACT(1'b0)) u_uadd (
        .lo(req_lo), .hi(req_hi), .af(req_af), .res(r_uadd));
    dau_unpacked #(.SUBTRACT(1'b1)) u_usub (
        .lo(req_lo), .hi(req_hi), .af(req_af), .res(r_usub));
    dau_packed #(.SUBTRACT(1'b0)) u_padd (
        .lo(req_lo), .hi(req_hi), .cf(req_cf), .af(req_af), .res(r_padd));
    dau_packed #(.SUBTRACT(1'b1)) u_psub (
        .lo(req_lo), .hi(req_hi), .cf(req_cf), .af(req_af), .res(r_psub));
    dau_base u_base (
        .lo(req_lo), .hi(req_hi), .base(req_base),
        .split_res(r_split), .fold_res(r_fold));

    always_comb begin
        fault = 1'b0;
        pick  = '{lo: req_lo, hi: req_hi, cf: req_cf, af: req_af};
        unique case (op)
            OP_UADD:  pick = r_uadd;
            OP_USUB:  pick = r_usub;
            OP_PADD:  pick = r_padd;
            OP_PSUB:  pick = r_psub;
            OP_MADJ: begin
                if (req_base == '0) fault = 1'b1;
                else                pick  = r_split;
            end
            OP_DPREP: pick = r_fold;
            default:  fault = 1'b1;
        endcase
    end

    always_comb begin
        nxt.lo  = pick.lo;
        nxt.hi  = pick.hi;
        nxt.cf  = pick.cf;
        nxt.af  = pick.af;
        nxt.zf  = (pick.lo == '0);
        nxt.sf  = pick.lo[BYTE_W-1];
        nxt.pf  = even_ones(pick.lo);
        nxt.err = fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_lo    = cur.lo;
    assign rsp_hi    = cur.hi;
    assign rsp_cf    = cur.cf;
    assign rsp_af    = cur.af;
    assign rsp_zf    = cur.zf;
    assign rsp_sf    = cur.sf;
    assign rsp_pf    = cur.pf;
    assign rsp_err   = cur.err;
endmodule

// File: rtl/dau_checker.sv
module dau_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [7:0] req_lo,
    input logic [7:0] req_hi,
    input logic       rsp_valid,
    input logic [7:0] rsp_lo,
    input logic [7:0] rsp_hi,
    input logic       rsp_cf,
    input logic       rsp_af,
    input logic       rsp_sf,
    input logic       rsp_err
);
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == ($past(req_valid) && !$past(rst)));

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(req_valid) && !$past(rst)) |-> ($stable(rsp_lo) && $stable(rsp_hi)));

    assert_unpacked_form_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(req_op) <= 3'd1)) |-> (rsp_lo[7:4] == 4'd0 && rsp_cf == rsp_af));

    assert_sign_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> (rsp_sf == rsp_lo[7]));

    assert_base_flags_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && ($past(req_op) == 3'd4 || $past(req_op) == 3'd5))
        |-> (!rsp_cf && !rsp_af));

    assert_fold_hi_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == 3'd5) |-> (rsp_hi == 8'd0));

    assert_err_unchanged_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_lo == $past(req_lo) && rsp_hi == $past(req_hi)));

    assert_packed_hi_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(req_op) == 3'd2 || $past(req_op) == 3'd3))
        |-> (rsp_hi == $past(req_hi)));
endmodule

bind dau_top dau_checker u_dau_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_lo(req_lo), .req_hi(req_hi), .rsp_valid(rsp_valid),
    .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_cf(rsp_cf), .rsp_af(rsp_af),
    .rsp_sf(rsp_sf), .rsp_err(rsp_err)
);

// File: tb/tb_dau_top.sv
`timescale 1ns/1ps
module tb_dau_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_lo = '0, req_hi = '0, req_base = '0;
    logic       req_cf = 1'b0, req_af = 1'b0;
    logic       rsp_valid, rsp_cf, rsp_af, rsp_zf, rsp_sf, rsp_pf, rsp_err;
    logic [7:0] rsp_lo, rsp_hi;

    int checks = 0;
    int errors = 0;
    logic [21:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dau_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_lo(req_lo), .req_hi(req_hi), .req_cf(req_cf), .req_af(req_af),
        .req_base(req_base), .rsp_valid(rsp_valid), .rsp_lo(rsp_lo),
        .rsp_hi(rsp_hi), .rsp_cf(rsp_cf), .rsp_af(rsp_af), .rsp_zf(rsp_zf),
        .rsp_sf(rsp_sf), .rsp_pf(rsp_pf), .rsp_err(rsp_err)
    );

    // Expected {err, lo, hi, cf, af, zf, sf, pf} from the written rules
    function automatic logic [21:0] model(input int op, input int al, input int ah,
                                          input int cf, input int af, input int base);
        int ral = al, rah = ah, rcf = cf, raf = af, err = 0;
        bit fix = ((al & 15) > 9) || (af != 0);
        logic [7:0] b;
        case (op)
            0: if (fix) begin ral = (al + 6) & 15; rah = (ah + 1 + (al > 249 ? 1 : 0)) & 255;
                   rcf = 1; raf = 1; end
               else begin ral = al & 15; rcf = 0; raf = 0; end
            1: if (fix) begin ral = (al - 6) & 15; rah = (ah - 1 - (al < 6 ? 1 : 0)) & 255;
                   rcf = 1; raf = 1; end
               else begin ral = al & 15; rcf = 0; raf = 0; end
            2: begin rcf = 0; raf = 0;
                   if (fix) begin ral = (ral + 6) & 255; raf = 1; end
                   if (al > 153 || cf != 0) begin ral = (ral + 96) & 255; rcf = 1; end
               end
            3: begin rcf = 0; raf = 0;
                   if (fix) begin raf = 1; if (al < 6 || cf != 0) rcf = 1; ral = (al - 6) & 255; end
                   if (al > 153 || cf != 0) begin ral = (ral - 96) & 255; rcf = 1; end
               end
            4: if (base == 0) err = 1;
               else begin ral = al % base; rah = al / base; rcf = 0; raf = 0; end
            5: begin ral = (ah * base + al) & 255; rah = 0; rcf = 0; raf = 0; end
            default: err = 1;
        endcase
        b = 8'(ral);
        return {1'(err), b, 8'(rah), 1'(rcf), 1'(raf), (b == 8'd0), b[7], ~^b};
    endfunction

    task automatic drive(input int op, input int al, input int ah, input int cf,
                         input int af, input int base, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_lo = 8'(al); req_hi = 8'(ah);
        req_cf = 1'(cf); req_af = 1'(af); req_base = 8'(base);
        exp_q.push_back(model(op, al, ah, cf, af, base));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares every response against the scoreboard head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            logic [21:0] act, exp_v;
            string t;
            act = {rsp_err, rsp_lo, rsp_hi, rsp_cf, rsp_af, rsp_zf, rsp_sf, rsp_pf};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected response act=%h exp=none", act);
            end else begin
                exp_v = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== exp_v) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", t, act, exp_v);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R1 watchdog expired act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({rsp_valid, rsp_lo, rsp_hi, rsp_cf, rsp_af, rsp_zf, rsp_sf, rsp_pf, rsp_err} !== '0) begin
            errors++;
            $display("FAIL R1 reset state act=%h exp=0", {rsp_valid, rsp_lo, rsp_hi});
        end
        rst = 1'b0;

        // Named corners
        drive(0, 8'h0B, 8'h01, 0, 0, 0, "R2 uadd digit over");
        drive(0, 8'h05, 8'h07, 1, 0, 0, "R2 uadd no adjust");
        drive(0, 8'hFA, 8'h10, 0, 0, 0, "R3 uadd extra carry");
        drive(0, 8'hF9, 8'h10, 0, 1, 0, "R3 uadd at limit");
        drive(1, 8'h03, 8'h05, 0, 1, 0, "R4 usub borrow");
        drive(1, 8'h0E, 8'h00, 0, 0, 0, "R4 usub wrap");
        drive(2, 8'h9A, 8'h33, 0, 0, 0, "R5 padd both steps");
        drive(2, 8'h00, 8'h44, 1, 0, 0, "R5 padd carry in");
        drive(3, 8'h03, 8'h12, 0, 1, 0, "R6 psub low step only");
        drive(3, 8'h03, 8'h12, 1, 1, 0, "R6 psub both steps");
        drive(3, 8'h9A, 8'h12, 0, 0, 0, "R6 psub over 99");
        drive(4, 8'd47, 8'hAA, 1, 1, 10, "R8 madj base 10");
        drive(4, 8'd200, 8'h00, 0, 0, 7, "R8 madj base 7");
        drive(4, 8'd0, 8'h00, 0, 0, 1, "R7 madj zero result");
        drive(5, 8'd9, 8'd4, 1, 1, 10, "R9 dprep base 10");
        drive(5, 8'd255, 8'd255, 0, 0, 255, "R9 dprep wrap");
        drive(4, 8'h81, 8'h22, 1, 0, 0, "R10 madj base zero");
        drive(6, 8'h3C, 8'h55, 0, 1, 9, "R10 reserved 6");
        drive(7, 8'h00, 8'h66, 1, 1, 9, "R10 reserved 7");
        drive(2, 8'h45, 8'hEE, 1, 1, 0, "R11 padd keeps hi");
        idle();
        idle();
        // Hold: outputs must not move without a request
        begin
            logic [7:0] lo_s, hi_s;
            lo_s = rsp_lo; hi_s = rsp_hi;
            idle(); idle();
            checks++;
            if (rsp_lo !== lo_s || rsp_hi !== hi_s || rsp_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 hold act=%h%h exp=%h%h", rsp_lo, rsp_hi, lo_s, hi_s);
            end
        end

        // Sweeps over every low byte and flag combination, back to back
        for (int op = 0; op < 4; op++)
            for (int fl = 0; fl < 4; fl++)
                for (int a = 0; a < 256; a++)
                    drive(op, a, (a * 37 + op) & 255, fl & 1, fl >> 1, 0,
                          op == 0 ? "R2 R3 sweep" : op == 1 ? "R4 sweep" :
                          op == 2 ? "R5 R11 sweep" : "R6 R11 sweep");
        for (int a = 0; a < 256; a++)
            drive(4, a, 8'h5A, 0, 1, (a % 13) + 1, "R8 R7 sweep");
        for (int a = 0; a < 256; a++)
            drive(5, a, (a * 11) & 255, 1, 0, (a * 7) & 255, "R9 R7 sweep");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing responses act=%0d exp=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule